// File: doc/BRIEF.md
# Single-Precision NaN Screening and Quieting Unit

This combinational unit examines one binary floating-point operand (single precision by default) and sorts it into one of six classes. It also reports whether the operand is a NaN and whether that NaN is signaling. When the operand is a signaling NaN, the unit produces a quieted copy and raises an invalid-operation flag. Any other operand passes through to the result unchanged.

Two NaN conventions are supported, and a single input selects between them. With `ieee2008_i` high, the unit uses the 2008 convention: a set top fraction bit marks a quiet NaN. With `ieee2008_i` low, it uses the legacy convention, where the polarity of that bit is reversed. In legacy mode, quieting clears the top fraction bit. If that clearing would leave a zero fraction, which would encode an infinity, the unit sets the next fraction bit so that the result is still a NaN.

The class decode comes from two checks on the exponent field: all zeros or all ones. The fraction then refines it. The six classes are zero, subnormal, normal, infinity, quiet NaN and signaling NaN. Exponent and fraction widths are parameters, and the field layout is {sign, exponent, fraction}.

Top module: `f32_nan_screen`

## Requirements
- R1: `is_nan_o` is high exactly when the exponent field is all ones and the fraction field is nonzero.
- R2: `is_snan_o` is high exactly when the operand is a NaN and (`ieee2008_i` XOR fraction MSB) is 1. With `ieee2008_i`=1, a NaN whose fraction MSB (bit 22 by default) is clear is signaling. With `ieee2008_i`=0, a NaN whose fraction MSB is set is signaling.
- R3: `class_o` is one-hot. Bit 0 is zero (exponent 0, fraction 0). Bit 1 is subnormal (exponent 0, fraction nonzero). Bit 2 is normal (any other exponent). Bit 3 is infinity (exponent all ones, fraction 0). Bit 4 is quiet NaN. Bit 5 is signaling NaN.
- R4: `invalid_o` is high exactly when the operand is a signaling NaN under the selected convention.
- R5: With `ieee2008_i`=1 and a signaling NaN, `quiet_o` equals the operand with the fraction MSB set.
- R6: With `ieee2008_i`=0 and a signaling NaN, `quiet_o` equals the operand with the fraction MSB cleared. If the fraction is then zero, fraction bit MSB-1 (bit 21 by default) is also set.
- R7: For a signaling NaN, the sign bit and exponent field of `quiet_o` equal those of the operand.
- R8: For any operand that is not a signaling NaN, `quiet_o` equals the operand and `invalid_o` is low.
- R9: Whenever `invalid_o` is high, `quiet_o` is a quiet NaN under the same convention: its exponent is all ones, its fraction is nonzero, and (`ieee2008_i` XOR its fraction MSB) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 1+EXP_W+FRAC_W (32) | Operand laid out as {sign, exponent, fraction} |
| ieee2008_i | input | 1 | 1 selects the 2008 NaN convention, 0 the legacy one |
| is_nan_o | output | 1 | Operand is a NaN of either kind |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| class_o | output | 6 | One-hot class of the operand |
| quiet_o | output | 1+EXP_W+FRAC_W (32) | Quieted operand, or the operand unchanged |
| invalid_o | output | 1 | Invalid-operation flag raised by quieting |

## Verification
The hardest case to reach is the legacy fix-up. It needs a NaN whose only set fraction bit is the MSB, presented with the legacy convention selected, and a single fraction pattern out of millions produces it. The bench reaches it in two ways. It builds a second instance with a 3-bit exponent and a 4-bit fraction and sweeps every operand under both conventions, so each fix-up encoding, with both signs, is applied. On the single-precision instance it drives a directed grid of exponent and fraction corners, including the lone-MSB fraction.

// File: rtl/fnan_pkg.sv
package fnan_pkg;

    // Operand classes; the enum value is the bit position in the one-hot output.
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } fp_cls_e;

    localparam int NUM_CLS = 6;

    // Field summary produced by the classifier.
    typedef struct packed {
        logic exp_max;
        logic exp_zero;
        logic frac_zero;
        logic frac_msb;
    } fp_flags_t;

    function automatic logic [NUM_CLS-1:0] cls_onehot(input fp_cls_e c);
        return NUM_CLS'(1) << c;
    endfunction

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
    import fnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd_i,
    input  logic                  ieee2008_i,
    output fp_flags_t             flags_o,
    output fp_cls_e               cls_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              sig_sel;

    assign exp_f  = opnd_i[W-2 -: EXP_W];
    assign frac_f = opnd_i[FRAC_W-1:0];

    always_comb begin
        flags_o.exp_max   = &exp_f;
        flags_o.exp_zero  = ~|exp_f;
        flags_o.frac_zero = ~|frac_f;
        flags_o.frac_msb  = frac_f[FRAC_W-1];
    end

    // A NaN is signaling when the convention bit and the quiet-indicator disagree.
    assign sig_sel = ieee2008_i ^ flags_o.frac_msb;

    always_comb begin
        unique case ({flags_o.exp_zero, flags_o.exp_max})
            2'b10:   cls_o = flags_o.frac_zero ? CLS_ZERO : CLS_SUB;
            2'b01:   cls_o = flags_o.frac_zero ? CLS_INF
                           : (sig_sel ? CLS_SNAN : CLS_QNAN);
            default: cls_o = CLS_NORM;
        endcase
    end

endmodule

// File: rtl/fnan_quieter.sv
module fnan_quieter #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd_i,
    input  logic                  ieee2008_i,
    input  logic                  snan_i,
    output logic [EXP_W+FRAC_W:0] quiet_o,
    output logic                  invalid_o
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] MSB_MASK = W'(1) << (FRAC_W - 1);

    logic [W-1:0] set_path;
    logic [W-1:0] clr_path;
    logic [W-1:0] fix_path;

    assign set_path = opnd_i | MSB_MASK;
    assign clr_path = opnd_i & ~MSB_MASK;

    generate
        if (FRAC_W >= 2) begin : g_fixup
            localparam logic [W-1:0] NEXT_MASK = W'(1) << (FRAC_W - 2);
            // Keep the cleared value a NaN: an empty fraction gets the next bit.
            assign fix_path = (~|clr_path[FRAC_W-1:0]) ? (clr_path | NEXT_MASK)
                                                       : clr_path;
        end else begin : g_nofix
            assign fix_path = clr_path;
        end
    endgenerate

    always_comb begin
        quiet_o   = opnd_i;
        invalid_o = 1'b0;
        if (snan_i) begin
            invalid_o = 1'b1;
            quiet_o   = ieee2008_i ? set_path : fix_path;
        end
    end

endmodule

// File: rtl/f32_nan_screen.sv
module f32_nan_screen
    import fnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd_i,
    input  logic                  ieee2008_i,
    output logic                  is_nan_o,
    output logic                  is_snan_o,
    output logic [5:0]            class_o,
    output logic [EXP_W+FRAC_W:0] quiet_o,
    output logic                  invalid_o
);
    fp_flags_t flags;
    fp_cls_e   cls;
    logic      snan;

    fnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .opnd_i    (opnd_i),
        .ieee2008_i(ieee2008_i),
        .flags_o   (flags),
        .cls_o     (cls)
    );

    assign snan = (cls == CLS_SNAN);

    fnan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quieter (
        .opnd_i    (opnd_i),
        .ieee2008_i(ieee2008_i),
        .snan_i    (snan),
        .quiet_o   (quiet_o),
        .invalid_o (invalid_o)
    );

    always_comb begin
        class_o   = cls_onehot(cls);
        is_snan_o = snan;
        is_nan_o  = (cls == CLS_QNAN) || snan;
    end

    // flags is consumed inside the classifier; expose nothing more.
    logic unused_flags;
    assign unused_flags = ^flags;

endmodule

// File: rtl/f32_nan_screen_chk.sv
module f32_nan_screen_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic [EXP_W+FRAC_W:0] opnd_i,
    input logic                  ieee2008_i,
    input logic                  is_nan_o,
    input logic                  is_snan_o,
    input logic [5:0]            class_o,
    input logic [EXP_W+FRAC_W:0] quiet_o,
    input logic                  invalid_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic in_nan, out_nan;
    logic in_sig, out_sig;

    assign in_nan  = (&opnd_i[W-2 -: EXP_W]) && (|opnd_i[FRAC_W-1:0]);
    assign out_nan = (&quiet_o[W-2 -: EXP_W]) && (|quiet_o[FRAC_W-1:0]);
    assign in_sig  = ieee2008_i ^ opnd_i[FRAC_W-1];
    assign out_sig = ieee2008_i ^ quiet_o[FRAC_W-1];

    always_comb begin
        if (!$isunknown({opnd_i, ieee2008_i})) begin
            assert_nan_flag_R1: assert (is_nan_o == in_nan)
                else $error("is_nan_o disagrees with operand fields");
            assert_snan_flag_R2: assert (is_snan_o == (in_nan && in_sig))
                else $error("is_snan_o disagrees with convention");
            assert_class_onehot_R3: assert ($countones(class_o) == 1)
                else $error("class_o not one-hot");
            assert_class_nan_R3: assert ((class_o[4] | class_o[5]) == is_nan_o)
                else $error("class_o NaN bits disagree with is_nan_o");
            assert_invalid_R4: assert (invalid_o == (in_nan && in_sig))
                else $error("invalid_o wrong");
            assert_fields_kept_R7: assert (!invalid_o ||
                quiet_o[W-1 -: EXP_W+1] == opnd_i[W-1 -: EXP_W+1])
                else $error("sign or exponent changed while quieting");
            assert_passthru_R8: assert (invalid_o || quiet_o == opnd_i)
                else $error("non-signaling operand altered");
            assert_result_quiet_R9: assert (!invalid_o || (out_nan && !out_sig))
                else $error("quieted result is not a quiet NaN");
        end
    end

endmodule

bind f32_nan_screen f32_nan_screen_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .opnd_i    (opnd_i),
    .ieee2008_i(ieee2008_i),
    .is_nan_o  (is_nan_o),
    .is_snan_o (is_snan_o),
    .class_o   (class_o),
    .quiet_o   (quiet_o),
    .invalid_o (invalid_o)
);

// File: tb/f32_nan_screen_bench.sv
module f32_nan_screen_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Full single-precision instance.
    logic [31:0] opnd_f;
    logic        mode_f;
    logic        nan_f, snan_f, inv_f;
    logic [5:0]  cls_f;
    logic [31:0] q_f;

    f32_nan_screen u_f32_nan_screen (
        .opnd_i(opnd_f), .ieee2008_i(mode_f), .is_nan_o(nan_f), .is_snan_o(snan_f),
        .class_o(cls_f), .quiet_o(q_f), .invalid_o(inv_f)
    );

    // Small instance: 3-bit exponent, 4-bit fraction, swept exhaustively.
    logic [7:0] opnd_s;
    logic       mode_s;
    logic       nan_s, snan_s, inv_s;
    logic [5:0] cls_s;
    logic [7:0] q_s;

    f32_nan_screen #(.EXP_W(3), .FRAC_W(4)) u_small (
        .opnd_i(opnd_s), .ieee2008_i(mode_s), .is_nan_o(nan_s), .is_snan_o(snan_s),
        .class_o(cls_s), .quiet_o(q_s), .invalid_o(inv_s)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Reference computed from the requirement text.
    function automatic void model(input int E, input int F, input logic [31:0] x,
                                  input logic m, output logic nan, output logic snan,
                                  output logic [5:0] cls, output logic [31:0] q);
        logic [31:0] emask, fmask, ex, fr, y;
        logic msb;
        emask = (32'd1 << E) - 1;
        fmask = (32'd1 << F) - 1;
        ex    = (x >> F) & emask;
        fr    = x & fmask;
        msb   = fr[F-1];
        nan   = (ex == emask) && (fr != 0);
        snan  = nan && (m ^ msb);
        if (ex == 0)           cls = (fr == 0) ? 6'b000001 : 6'b000010;
        else if (ex != emask)  cls = 6'b000100;
        else if (fr == 0)      cls = 6'b001000;
        else                   cls = snan ? 6'b100000 : 6'b010000;
        q = x;
        if (snan) begin
            if (m) q = x | (32'd1 << (F-1));
            else begin
                y = x & ~(32'd1 << (F-1));
                if ((y & fmask) == 0) y = y | (32'd1 << (F-2));
                q = y;
            end
        end
    endfunction

    task automatic compare(input int E, input int F, input logic [31:0] x, input logic m,
                           input logic a_nan, input logic a_snan, input logic [5:0] a_cls,
                           input logic [31:0] a_q, input logic a_inv);
        logic en, es, qn, qs;
        logic [5:0] ec, qc;
        logic [31:0] eq, qq;
        int W;
        W = 1 + E + F;
        model(E, F, x, m, en, es, ec, eq);
        chk("R1", "is_nan", {31'd0, a_nan}, {31'd0, en});
        chk("R2", "is_snan", {31'd0, a_snan}, {31'd0, es});
        chk("R3", "class", {26'd0, a_cls}, {26'd0, ec});
        chk("R4", "invalid", {31'd0, a_inv}, {31'd0, es});
        if (!es) chk("R8", "passthrough", a_q, x);
        else begin
            chk(m ? "R5" : "R6", "quiet", a_q, eq);
            chk("R7", "sign_exp", a_q >> F, x >> F);
            model(E, F, a_q & ((W == 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 1)), m,
                  qn, qs, qc, qq);
            chk("R9", "result_quiet", {30'd0, qn, qs}, 32'd2);
        end
    endtask

    task automatic run_full(input logic [31:0] x, input logic m);
        @(posedge clk);
        opnd_f = x;
        mode_f = m;
        @(negedge clk);
        compare(8, 23, x, m, nan_f, snan_f, cls_f, q_f, inv_f);
    endtask

    task automatic run_small(input logic [7:0] x, input logic m);
        @(posedge clk);
        opnd_s = x;
        mode_s = m;
        @(negedge clk);
        compare(3, 4, {24'd0, x}, m, nan_s, snan_s, cls_s, {24'd0, q_s}, inv_s);
    endtask

    initial begin
        logic [31:0] fr_list [7];
        logic [7:0]  ex_list [5];
        opnd_f = 32'd0; mode_f = 1'b1;
        opnd_s = 8'd0;  mode_s = 1'b1;
        fr_list = '{32'h0, 32'h1, 32'h200000, 32'h400000, 32'h400001, 32'h7FFFFF, 32'h3FFFFF};
        ex_list = '{8'h00, 8'h01, 8'h7F, 8'hFE, 8'hFF};

        // Initial state: zero operand classifies as zero, nothing raised.
        @(negedge clk);
        chk("R3", "initial_class", {26'd0, cls_f}, 32'd1);
        chk("R8", "initial_invalid", {31'd0, inv_f}, 32'd0);

        // Legacy fix-up corner on the full-width instance, both signs.
        run_full(32'h7FC00000, 1'b0);
        chk("R6", "fixup_pos", q_f, 32'h7FA00000);
        run_full(32'hFFC00000, 1'b0);
        chk("R6", "fixup_neg", q_f, 32'hFFA00000);
        // 2008 quieting of a lone low bit.
        run_full(32'h7F800001, 1'b1);
        chk("R5", "set_msb", q_f, 32'h7FC00001);

        // Directed grid on the full-width instance.
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++)
                for (int e = 0; e < 5; e++)
                    for (int f = 0; f < 7; f++)
                        run_full({s[0], ex_list[e], fr_list[f][22:0]}, m[0]);

        // Exhaustive sweep on the small instance.
        for (int m = 0; m < 2; m++)
            for (int v = 0; v < 256; v++)
                run_small(v[7:0], m[0]);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule